// File: doc/BRIEF.md
# UART Type Detection Probe Sequencer

This block is a small bus master that works out which kind of PC-style serial controller sits in a register window. Software or a boot sequencer gives it a base address and a start pulse. The block then runs a fixed series of reads and writes over a simple synchronous register bus and sorts the device into one of four classes. The classes are: no scratch register, scratch register with no FIFOs, FIFOs flagged as faulty, and working FIFOs.

The probe has two parts. It first checks that the scratch register at offset 7 holds two complementary test patterns. It then reads the interrupt identification register at offset 2 before and after writing 1 to the FIFO control register at the same offset. The two top bits of the second read choose the class. Every register the probe changes is written back before it finishes: the scratch byte always, and the FIFO control register when the FIFOs were off at the start. The result appears on a 2-bit code together with a one-cycle done pulse.

Top module: `uart_type_probe`

## Requirements
- R1: After synchronous reset the block is idle. Both bus strobes are low and `done` is low. They stay low until a start pulse arrives.
- R2: A start pulse in idle begins a probe. The first access is a read of base+7, whose value is saved.
- R3: The scratch test has four steps: write 0x5A to base+7, read it back, write 0xA5 to base+7, read it back. If either read-back differs from its pattern, the probe writes the saved byte to base+7 and then finishes with code 0. It makes no access to base+2 on this path.
- R4: When both patterns read back correctly, the saved scratch byte is written to base+7. After any probe, the device's scratch register again holds its value from before the probe.
- R5: After the scratch restore, the probe makes three accesses in this order: a read of base+2 (first identification value), a write of 0x01 to base+2, and a read of base+2 (second identification value).
- R6: The code comes from the second identification value. Bit 6 set gives code 3 (working FIFOs). Otherwise bit 7 set gives code 2 (faulty FIFOs). Otherwise the code is 1 (scratch only).
- R7: If bit 7 of the first identification value was clear, the last access is a write of 0x00 to base+2. If it was set, no access follows the second read. Either way the FIFO enable of the device ends as it began.
- R8: At most one strobe is high at a time. While a strobe is high and `bus_ready` is low, the strobe, `bus_addr` and `bus_wdata` hold their values. An access completes in a cycle where its strobe and `bus_ready` are both high.
- R9: `done` is high for exactly one cycle after the last access, and `dev_type` is valid in that cycle. A start pulse during a probe is ignored: the access sequence is not restarted and no extra accesses follow `done`.
- R10: The base address is taken when the probe starts. Every address is that base plus the offset, and changing `base_addr` during a probe has no effect on the addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a probe when the block is idle |
| base_addr | input | AW | Base of the device register window |
| bus_addr | output | AW | Access address |
| bus_wdata | output | 8 | Write data |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_rdata | input | 8 | Read data, sampled when read strobe and ready are both high |
| bus_ready | input | 1 | Completes the current access |
| done | output | 1 | One-cycle completion pulse |
| dev_type | output | 2 | Device class: 0 no scratch, 1 scratch only, 2 faulty FIFOs, 3 working FIFOs |

## Verification
The assertions assume that reset is held for at least one edge before the first start pulse. They also assume that the bus slave raises `bus_ready` only while a strobe is high, and that `bus_rdata` is settled in the cycle the read completes. The bench uses a behavioural slave that holds ready low for a varying number of cycles, or keeps it high for zero-wait runs. The slave asserts ready only in answer to a strobe. Start pulses and base changes are driven on the falling edge, so each of them falls on a single rising edge.

// File: rtl/uart_probe_pkg.sv
package uart_probe_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_SCR,
        ST_WR_PAT_A,
        ST_RD_PAT_A,
        ST_WR_PAT_B,
        ST_RD_PAT_B,
        ST_WR_SCR,
        ST_RD_IIR_A,
        ST_WR_FCR_ON,
        ST_RD_IIR_B,
        ST_WR_FCR_OFF,
        ST_DONE
    } step_t;

    typedef enum logic [1:0] {
        KIND_NO_SCR   = 2'd0,
        KIND_SCR_ONLY = 2'd1,
        KIND_FIFO_BAD = 2'd2,
        KIND_FIFO_OK  = 2'd3
    } kind_t;

    typedef struct packed {
        logic       active;
        logic       write;
        logic [2:0] offset;
        logic [7:0] data;
    } bus_op_t;

    localparam logic [2:0] OFF_SCRATCH = 3'd7;
    localparam logic [2:0] OFF_IDENT   = 3'd2;
    localparam logic [7:0] PAT_A       = 8'h5A;
    localparam logic [7:0] PAT_B       = 8'hA5;
    localparam logic [7:0] FCR_ON      = 8'h01;
    localparam logic [7:0] FCR_OFF     = 8'h00;

    // Bus operation issued while the sequencer sits in a given step.
    function automatic bus_op_t step_op(step_t s, logic [7:0] saved_scr);
        bus_op_t op;
        op = '{active: 1'b1, write: 1'b0, offset: OFF_SCRATCH, data: 8'h00};
        case (s)
            ST_RD_SCR:     ;
            ST_WR_PAT_A:   begin op.write = 1'b1; op.data = PAT_A; end
            ST_RD_PAT_A:   ;
            ST_WR_PAT_B:   begin op.write = 1'b1; op.data = PAT_B; end
            ST_RD_PAT_B:   ;
            ST_WR_SCR:     begin op.write = 1'b1; op.data = saved_scr; end
            ST_RD_IIR_A:   op.offset = OFF_IDENT;
            ST_WR_FCR_ON:  begin op.write = 1'b1; op.offset = OFF_IDENT; op.data = FCR_ON; end
            ST_RD_IIR_B:   op.offset = OFF_IDENT;
            ST_WR_FCR_OFF: begin op.write = 1'b1; op.offset = OFF_IDENT; op.data = FCR_OFF; end
            default:       op.active = 1'b0;
        endcase
        return op;
    endfunction

    // Pattern expected back from a scratch read-back step.
    function automatic logic [7:0] step_pattern(step_t s);
        return (s == ST_RD_PAT_B) ? PAT_B : PAT_A;
    endfunction

    function automatic logic is_pattern_read(step_t s);
        return (s == ST_RD_PAT_A) || (s == ST_RD_PAT_B);
    endfunction

    // Class from the two top bits of the identification value after enabling.
    function automatic kind_t classify(logic [1:0] ident_top);
        if (ident_top[0])      return KIND_FIFO_OK;
        else if (ident_top[1]) return KIND_FIFO_BAD;
        else                   return KIND_SCR_ONLY;
    endfunction

endpackage

// File: rtl/uart_probe_bus.sv
module uart_probe_bus
    import uart_probe_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_op_t       op,
    input  logic [AW-1:0] base,
    input  logic          bus_ready,
    output logic [AW-1:0] bus_addr,
    output logic [7:0]    bus_wdata,
    output logic          bus_rd,
    output logic          bus_wr,
    output logic          xfer
);

    always_comb begin
        bus_addr  = base + AW'(op.offset);
        bus_rd    = op.active && !op.write;
        bus_wr    = op.active && op.write;
        bus_wdata = op.write ? op.data : 8'h00;
        xfer      = op.active && bus_ready;
    end

    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr)) else $error("read and write strobes together"); // R8

    AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_wr) && !bus_ready) |=>
            ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_rd) && $stable(bus_wr)))
        else $error("access changed before ready"); // R8

endmodule

// File: rtl/uart_probe_capture.sv
module uart_probe_capture
    import uart_probe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  step_t      step,
    input  logic       xfer,
    input  logic [7:0] rdata,
    output logic [7:0] saved_scr,
    output logic       fifo_was_on,
    output logic       scratch_miss,
    output kind_t      kind
);

    always_comb begin
        scratch_miss = is_pattern_read(step) && (rdata != step_pattern(step));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            saved_scr   <= 8'h00;
            fifo_was_on <= 1'b0;
            kind        <= KIND_NO_SCR;
        end else if (xfer) begin
            case (step)
                ST_RD_SCR:   saved_scr   <= rdata;
                ST_RD_IIR_A: fifo_was_on <= rdata[7];
                ST_RD_IIR_B: kind        <= classify(rdata[7:6]);
                default:     if (scratch_miss) kind <= KIND_NO_SCR;
            endcase
        end
    end

endmodule

// File: rtl/uart_probe_seq.sv
module uart_probe_seq
    import uart_probe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  xfer,
    input  logic  scratch_miss,
    input  logic  fifo_was_on,
    output step_t step,
    output logic  launch,
    output logic  done
);

    step_t step_nx;
    logic  no_scr;

    assign launch = (step == ST_IDLE) && start;
    assign done   = (step == ST_DONE);

    always_comb begin
        step_nx = step;
        case (step)
            ST_IDLE:       if (start) step_nx = ST_RD_SCR;
            ST_RD_SCR:     if (xfer) step_nx = ST_WR_PAT_A;
            ST_WR_PAT_A:   if (xfer) step_nx = ST_RD_PAT_A;
            ST_RD_PAT_A:   if (xfer) step_nx = scratch_miss ? ST_WR_SCR : ST_WR_PAT_B;
            ST_WR_PAT_B:   if (xfer) step_nx = ST_RD_PAT_B;
            ST_RD_PAT_B:   if (xfer) step_nx = ST_WR_SCR;
            ST_WR_SCR:     if (xfer) step_nx = no_scr ? ST_DONE : ST_RD_IIR_A;
            ST_RD_IIR_A:   if (xfer) step_nx = ST_WR_FCR_ON;
            ST_WR_FCR_ON:  if (xfer) step_nx = ST_RD_IIR_B;
            ST_RD_IIR_B:   if (xfer) step_nx = fifo_was_on ? ST_DONE : ST_WR_FCR_OFF;
            ST_WR_FCR_OFF: if (xfer) step_nx = ST_DONE;
            ST_DONE:       step_nx = ST_IDLE;
            default:       step_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step   <= ST_IDLE;
            no_scr <= 1'b0;
        end else begin
            step <= step_nx;
            if (launch)
                no_scr <= 1'b0;
            else if (xfer && scratch_miss)
                no_scr <= 1'b1;
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done wider than one cycle"); // R9

endmodule

// File: rtl/uart_type_probe.sv
module uart_type_probe
    import uart_probe_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    output logic [AW-1:0] bus_addr,
    output logic [7:0]    bus_wdata,
    output logic          bus_rd,
    output logic          bus_wr,
    input  logic [7:0]    bus_rdata,
    input  logic          bus_ready,
    output logic          done,
    output logic [1:0]    dev_type
);

    step_t         step;
    logic          launch;
    logic          xfer;
    logic          scratch_miss;
    logic          fifo_was_on;
    logic [7:0]    saved_scr;
    kind_t         kind;
    logic [AW-1:0] base_q;
    bus_op_t       op;

    always_ff @(posedge clk) begin
        if (rst)         base_q <= '0;
        else if (launch) base_q <= base_addr;
    end

    assign op       = step_op(step, saved_scr);
    assign dev_type = kind;

    uart_probe_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .xfer         (xfer),
        .scratch_miss (scratch_miss),
        .fifo_was_on  (fifo_was_on),
        .step         (step),
        .launch       (launch),
        .done         (done)
    );

    uart_probe_capture u_cap (
        .clk          (clk),
        .rst          (rst),
        .step         (step),
        .xfer         (xfer),
        .rdata        (bus_rdata),
        .saved_scr    (saved_scr),
        .fifo_was_on  (fifo_was_on),
        .scratch_miss (scratch_miss),
        .kind         (kind)
    );

    uart_probe_bus #(.AW(AW)) u_bus (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .base      (base_q),
        .bus_ready (bus_ready),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .xfer      (xfer)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (step == ST_IDLE) |-> (!bus_rd && !bus_wr)) else $error("strobe while idle"); // R1

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (start && step != ST_IDLE) |=> $stable(base_q)) else $error("base reloaded mid-probe"); // R10

endmodule

// File: tb/uart_type_probe_bench.sv
`timescale 1ns/1ps
module uart_type_probe_bench;
    import uart_probe_pkg::*;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] base_in = '0;
    logic [AW-1:0] bus_addr;
    logic [7:0]    bus_wdata;
    logic          bus_rd, bus_wr;
    logic [7:0]    bus_rdata;
    logic          bus_ready;
    logic          done;
    logic [1:0]    dev_type;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    uart_type_probe #(.AW(AW)) u_uart_type_probe (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_in),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .done(done), .dev_type(dev_type)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    logic          m_has_scr = 1'b1, m_stuck = 1'b0, m_zero_wait = 1'b0;
    logic [1:0]    m_fifo = 2'd0;      // 0 none, 1 faulty, 2 working
    logic          m_fifo_en = 1'b0;
    logic [7:0]    m_scr = 8'h00;
    logic [AW-1:0] m_base = '0;
    logic          ready_q = 1'b0;
    logic [1:0]    wait_cnt = 2'd0;
    logic [3:0]    lfsr = 4'h9;
    logic [AW-1:0] m_off;

    assign m_off     = bus_addr - m_base;
    assign bus_ready = (bus_rd || bus_wr) && (m_zero_wait || ready_q);

    always_comb begin
        bus_rdata = 8'h00;
        if (m_off == AW'(7))
            bus_rdata = m_has_scr ? m_scr : 8'hFF;
        else if (m_off == AW'(2))
            bus_rdata = {m_fifo_en && m_fifo != 2'd0, m_fifo_en && m_fifo == 2'd2, 6'b000001};
    end

    always @(posedge clk) begin
        lfsr <= {lfsr[2:0], lfsr[3] ^ lfsr[2]};
        if (rst) begin
            ready_q  <= 1'b0;
            wait_cnt <= 2'd0;
        end else if (bus_rd || bus_wr) begin
            if (bus_ready) begin
                ready_q  <= 1'b0;
                wait_cnt <= lfsr[1:0];
                if (bus_wr && m_off == AW'(7) && m_has_scr)
                    m_scr <= m_stuck ? (bus_wdata & 8'hFE) : bus_wdata;
                if (bus_wr && m_off == AW'(2) && m_fifo != 2'd0)
                    m_fifo_en <= bus_wdata[0];
            end else if (wait_cnt == 2'd0) begin
                ready_q <= 1'b1;
            end else begin
                wait_cnt <= wait_cnt - 2'd1;
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit            wr;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        string         tag;
    } acc_t;

    acc_t  exp_q[$];
    logic [1:0] exp_kind_q[$];
    string kind_tag_q[$];
    logic  prev_done = 1'b0;

    task automatic push_acc(input bit wr, input logic [AW-1:0] addr,
                            input logic [7:0] data, input string tag);
        acc_t a;
        a.wr = wr; a.addr = addr; a.data = data; a.tag = tag;
        exp_q.push_back(a);
    endtask

    // Monitor: compares each completed access and each done pulse.
    always @(negedge clk) begin
        if (!rst) begin
            if ((bus_rd || bus_wr) && bus_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected access",
                          {7'd0, bus_wr, bus_addr, bus_wdata}, 32'h0);
                end else begin
                    acc_t e;
                    logic [7:0] ed;
                    e  = exp_q.pop_front();
                    ed = e.wr ? e.data : bus_wdata;
                    check(bus_wr == e.wr && bus_rd == !e.wr && bus_addr == e.addr && bus_wdata == ed,
                          e.tag, "access {wr,addr,data}",
                          {7'd0, bus_wr, bus_addr, bus_wdata}, {7'd0, e.wr, e.addr, ed});
                end
            end
            if (done) begin
                if (exp_kind_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected done", 32'(dev_type), 32'h0);
                end else begin
                    logic [1:0] k;
                    string t;
                    k = exp_kind_q.pop_front();
                    t = kind_tag_q.pop_front();
                    check(dev_type == k, t, "device class", 32'(dev_type), 32'(k));
                end
            end
            if (done && prev_done)
                check(1'b0, "R9", "done longer than one cycle", 32'd1, 32'd0);
        end
        prev_done = done;
    end

    // Driver: sets the device up, builds the expected stream, runs one probe.
    task automatic run_probe(input string name, input bit has_scr, input bit stuck,
                             input logic [1:0] fifo, input bit fifo_init,
                             input logic [7:0] scr_init, input bit zero_wait,
                             input logic [AW-1:0] base, input bit disturb);
        logic [7:0] saved, rd_a, rd_b;
        logic [1:0] kind;
        bit seen;
        string atag;
        @(negedge clk);
        m_has_scr   = has_scr;
        m_stuck     = stuck;
        m_fifo      = fifo;
        m_fifo_en   = (fifo != 2'd0) && fifo_init;
        m_scr       = stuck ? (scr_init & 8'hFE) : scr_init;
        m_zero_wait = zero_wait;
        m_base      = base;
        base_in     = base;
        atag        = disturb ? "R10" : "R2";
        saved = has_scr ? m_scr : 8'hFF;
        rd_a  = has_scr ? (stuck ? (PAT_A & 8'hFE) : PAT_A) : 8'hFF;
        rd_b  = has_scr ? (stuck ? (PAT_B & 8'hFE) : PAT_B) : 8'hFF;
        push_acc(1'b0, base + 16'd7, 8'h00, atag);
        push_acc(1'b1, base + 16'd7, PAT_A, "R3");
        push_acc(1'b0, base + 16'd7, 8'h00, "R3");
        if (rd_a != PAT_A) begin
            push_acc(1'b1, base + 16'd7, saved, "R3");
            kind = 2'd0;
        end else begin
            push_acc(1'b1, base + 16'd7, PAT_B, "R3");
            push_acc(1'b0, base + 16'd7, 8'h00, "R3");
            if (rd_b != PAT_B) begin
                push_acc(1'b1, base + 16'd7, saved, "R3");
                kind = 2'd0;
            end else begin
                push_acc(1'b1, base + 16'd7, saved, "R4");
                push_acc(1'b0, base + 16'd2, 8'h00, "R5");
                push_acc(1'b1, base + 16'd2, FCR_ON, "R5");
                push_acc(1'b0, base + 16'd2, 8'h00, disturb ? "R10" : "R5");
                if (!((fifo != 2'd0) && fifo_init))
                    push_acc(1'b1, base + 16'd2, FCR_OFF, "R7");
                kind = (fifo == 2'd2) ? 2'd3 : (fifo == 2'd1) ? 2'd2 : 2'd1;
            end
        end
        exp_kind_q.push_back(kind);
        kind_tag_q.push_back(kind == 2'd0 ? "R3" : "R6");
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            repeat (5) @(negedge clk);
            base_in = base ^ 16'h0F00;
            start   = 1'b1;
            @(negedge clk);
            start   = 1'b0;
        end
        seen = 1'b0;
        for (int i = 0; i < 4000 && !seen; i++) begin
            @(negedge clk);
            seen = done;
        end
        check(seen, "R9", {name, ": done seen"}, 32'(seen), 32'd1);
        repeat (12) @(negedge clk);
        check(exp_q.size() == 0 && exp_kind_q.size() == 0, "R9", {name, ": stream consumed"},
              32'(exp_q.size()), 32'd0);
        if (has_scr)
            check(m_scr == saved, "R4", {name, ": scratch restored"}, 32'(m_scr), 32'(saved));
        check(m_fifo_en == ((fifo != 2'd0) && fifo_init), "R7", {name, ": fifo state restored"},
              32'(m_fifo_en), 32'((fifo != 2'd0) && fifo_init));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!bus_rd && !bus_wr && !done, "R1", "idle after reset",
                  {29'd0, bus_rd, bus_wr, done}, 32'd0);
        end
        run_probe("no scratch",        1'b0, 1'b0, 2'd2, 1'b0, 8'h00, 1'b1, 16'h03F8, 1'b0);
        run_probe("stuck scratch bit", 1'b1, 1'b1, 2'd2, 1'b0, 8'h3C, 1'b0, 16'h02F8, 1'b0);
        run_probe("scratch only",      1'b1, 1'b0, 2'd0, 1'b0, 8'h77, 1'b0, 16'h1000, 1'b0);
        run_probe("faulty fifo off",   1'b1, 1'b0, 2'd1, 1'b0, 8'hC3, 1'b0, 16'h2008, 1'b0);
        run_probe("faulty fifo on",    1'b1, 1'b0, 2'd1, 1'b1, 8'h00, 1'b1, 16'h3010, 1'b0);
        run_probe("good fifo off",     1'b1, 1'b0, 2'd2, 1'b0, 8'hFF, 1'b0, 16'h03E8, 1'b0);
        run_probe("good fifo on",      1'b1, 1'b0, 2'd2, 1'b1, 8'h5A, 1'b0, 16'h02E8, 1'b1);
        run_probe("good zero wait",    1'b1, 1'b0, 2'd2, 1'b0, 8'h12, 1'b1, 16'hFFF0, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R9", "watchdog expired", 32'd0, 32'd1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule